// File: doc/BRIEF.md
# Omega Multistage Interconnect Router

This block connects N request ports to N delivery ports through a blocking
multistage network. It has log2 N columns of two-by-two switch elements. Before
each column the lanes pass through a perfect shuffle, which moves the word on
position p to the position given by rotating p left by one bit. Each element
reads one destination bit of the request in front of it. The bit that steers a
column is the most significant one still unused: column 0 uses bit log2 N - 1,
and the last column uses bit 0.

A request is made of a valid flag, a destination index, a broadcast mask and a
data word. A set bit in the mask tells the element at that column to copy the
request to both of its outputs, so one request can reach a group of ports. Two
requests may need the same element output. In that case the request on the
element's upper input (the even position) keeps the output. The request on the
lower input is dropped at that element and its source is flagged as blocked.
Routing is combinational from the inputs. The delivered words, their source
indices and the per-source grant or blocked flags are registered, so they appear
one clock after the request.

Top module: `omega_router`

## Requirements
- R1: While the synchronous active-low reset is held, and right after it is released, every output reads zero: out_valid, out_src, out_data, req_grant and req_blocked.
- R2: Results appear exactly one clock after the request cycle. Input ports with in_valid low are ignored whatever their destination, mask and data, so an all-idle cycle gives out_valid = 0 and no grant or blocked flag on the next clock.
- R3: A valid unicast request (mask 0) from input i to destination d that is not blocked appears on output d one clock later, with out_src[d] = i and out_data[d] equal to in_data[i].
- R4: Conflict-free patterns are delivered in full with every valid source granted. The identity pattern (i to i) is one such pattern, and so is a uniform cyclic shift (i to (i+3) mod N).
- R5: In column 0, input i enters the element position rotl(i). Inputs i and i+N/2 therefore share element i mod (N/2), and input i is on the upper input. When both need the same element output, input i is delivered and input i+N/2 is blocked. For example, with N = 8: 0 to 1 against 4 to 0, and 0 to 4 against 4 to 5.
- R6: The upper-input-wins rule also applies in later columns. With N = 8, input 0 to destination 0 and input 2 to destination 1 meet on element 0 of column 1. Input 0 is delivered and input 2 is blocked.
- R7: For each valid input, req_grant is 1 only when every copy of its request was delivered, and req_blocked is 1 when any copy was dropped. An input with in_valid low raises neither flag.
- R8: Bit b of in_mask marks destination bit b as don't-care. The request reaches every output whose index matches in_dest on all unmasked bits. With mask all ones it reaches all N outputs, and with N = 8, destination 1 and mask 3'b100 reach outputs 1 and 5.
- R9: A request on a lower element input that wants any output already held by the upper input is dropped as a whole at that element. Copies that split off in earlier columns are still delivered. With N = 8, a full broadcast from input 4 against 0 to 0 delivers only output 0. A full broadcast from input 1 against 0 to 0 delivers outputs 2 to 7 from input 1 and output 0 from input 0, leaves output 1 empty, and blocks input 1.
- R10: A broadcast on an upper element input beats a unicast on the lower input. With N = 8, a full broadcast from input 0 against 4 to 3 delivers all outputs from input 0 and blocks input 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Request present on each input port |
| in_dest | input | N x log2 N | Destination index per input port |
| in_mask | input | N x log2 N | Broadcast mask per input port; a set bit makes that destination bit don't-care |
| in_data | input | N x DW | Data word per input port |
| out_valid | output | N | Registered: a word was delivered on this output port |
| out_src | output | N x log2 N | Registered: index of the input whose word is on this output |
| out_data | output | N x DW | Registered: the delivered word |
| req_grant | output | N | Registered: the valid request of this input was delivered in full |
| req_blocked | output | N | Registered: the valid request of this input lost a switch output |

## Verification
Delivery and conflict resolution fall in the same cycle. The winner of a collision must be routed correctly, the loser must be flagged, and its copies must be missing from the outputs, all on the same clock. The bench provokes this with directed pairs that meet on a chosen element in the first column and in a later column. It also mixes broadcasts with unicasts on both the upper and the lower side of an element, including a broadcast that loses one branch late in the network. Each scenario is judged against hand-derived paths by checking, on the single result clock, the full out_valid vector, the source and data on every delivered port, and the grant and blocked vectors together.

// File: rtl/omega_pkg.sv
// Shared definitions for the omega router.
// Holds the request decode of one element input. The decode turns valid, the
// destination bit of the current column and the matching mask bit into the set
// of element outputs the request needs.
package omega_pkg;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_UP   = 2'b01,
        ROUTE_LO   = 2'b10,
        ROUTE_BOTH = 2'b11
    } route_e;

    // Map one element input onto the outputs it asks for.
    function automatic route_e decode_route(input logic v, input logic dbit, input logic mbit);
        if (!v)
            return ROUTE_NONE;
        if (mbit)
            return ROUTE_BOTH;
        return dbit ? ROUTE_LO : ROUTE_UP;
    endfunction

endpackage

// File: rtl/omega_switch.sv
// Two-by-two switch element.
// Steers the upper and lower input lanes by destination bit BIT. A set mask bit
// BIT asks for both outputs. The upper input always keeps what it asks for.
// The lower input is dropped completely when it asks for any output the upper
// input holds, and lo_lost reports that loss.
// Assumes invalid lanes carry no meaning; outputs of empty lanes are zero.
module omega_switch
    import omega_pkg::*;
#(
    parameter int LOGN = 3,
    parameter int DW   = 8,
    parameter int BIT  = 0
) (
    input  logic            up_v,
    input  logic [LOGN-1:0] up_src,
    input  logic [LOGN-1:0] up_dst,
    input  logic [LOGN-1:0] up_msk,
    input  logic [DW-1:0]   up_dat,
    input  logic            lo_v,
    input  logic [LOGN-1:0] lo_src,
    input  logic [LOGN-1:0] lo_dst,
    input  logic [LOGN-1:0] lo_msk,
    input  logic [DW-1:0]   lo_dat,
    output logic            o0_v,
    output logic [LOGN-1:0] o0_src,
    output logic [LOGN-1:0] o0_dst,
    output logic [LOGN-1:0] o0_msk,
    output logic [DW-1:0]   o0_dat,
    output logic            o1_v,
    output logic [LOGN-1:0] o1_src,
    output logic [LOGN-1:0] o1_dst,
    output logic [LOGN-1:0] o1_msk,
    output logic [DW-1:0]   o1_dat,
    output logic            lo_lost
);

    route_e ru, rl;
    logic   u_w0, u_w1, l_w0, l_w1;
    logic   l_take0, l_take1;

    // Decode what each input asks for and settle the conflict.
    always_comb begin
        ru      = decode_route(up_v, up_dst[BIT], up_msk[BIT]);
        rl      = decode_route(lo_v, lo_dst[BIT], lo_msk[BIT]);
        u_w0    = (ru == ROUTE_UP) || (ru == ROUTE_BOTH);
        u_w1    = (ru == ROUTE_LO) || (ru == ROUTE_BOTH);
        l_w0    = (rl == ROUTE_UP) || (rl == ROUTE_BOTH);
        l_w1    = (rl == ROUTE_LO) || (rl == ROUTE_BOTH);
        lo_lost = (l_w0 && u_w0) || (l_w1 && u_w1);
        l_take0 = l_w0 && !lo_lost;
        l_take1 = l_w1 && !lo_lost;
    end

    // Drive the upper element output.
    always_comb begin
        o0_v   = 1'b0;
        o0_src = '0;
        o0_dst = '0;
        o0_msk = '0;
        o0_dat = '0;
        if (u_w0) begin
            o0_v = 1'b1; o0_src = up_src; o0_dst = up_dst; o0_msk = up_msk; o0_dat = up_dat;
        end else if (l_take0) begin
            o0_v = 1'b1; o0_src = lo_src; o0_dst = lo_dst; o0_msk = lo_msk; o0_dat = lo_dat;
        end
    end

    // Drive the lower element output.
    always_comb begin
        o1_v   = 1'b0;
        o1_src = '0;
        o1_dst = '0;
        o1_msk = '0;
        o1_dat = '0;
        if (u_w1) begin
            o1_v = 1'b1; o1_src = up_src; o1_dst = up_dst; o1_msk = up_msk; o1_dat = up_dat;
        end else if (l_take1) begin
            o1_v = 1'b1; o1_src = lo_src; o1_dst = lo_dst; o1_msk = lo_msk; o1_dat = lo_dat;
        end
    end

endmodule

// File: rtl/omega_stage.sv
// One network column: a perfect shuffle followed by N/2 switch elements.
// The shuffle moves lane p to position rotl(p). Column STAGE steers on
// destination bit LOGN-1-STAGE. blk has one bit per source index and marks the
// sources that lost a lower-input conflict in this column.
// Assumes N is a power of two and at least 2.
module omega_stage #(
    parameter int N     = 8,
    parameter int LOGN  = 3,
    parameter int DW    = 8,
    parameter int STAGE = 0
) (
    input  logic [N-1:0]           in_v,
    input  logic [N-1:0][LOGN-1:0] in_src,
    input  logic [N-1:0][LOGN-1:0] in_dst,
    input  logic [N-1:0][LOGN-1:0] in_msk,
    input  logic [N-1:0][DW-1:0]   in_dat,
    output logic [N-1:0]           out_v,
    output logic [N-1:0][LOGN-1:0] out_src,
    output logic [N-1:0][LOGN-1:0] out_dst,
    output logic [N-1:0][LOGN-1:0] out_msk,
    output logic [N-1:0][DW-1:0]   out_dat,
    output logic [N-1:0]           blk
);

    localparam int HALF = N / 2;
    localparam int BIT  = LOGN - 1 - STAGE;

    logic [N-1:0]           sh_v;
    logic [N-1:0][LOGN-1:0] sh_src, sh_dst, sh_msk;
    logic [N-1:0][DW-1:0]   sh_dat;
    logic [HALF-1:0]        lost;

    // Perfect shuffle wiring: lane p lands on rotl(p).
    for (genvar p = 0; p < N; p++) begin : g_shuffle
        localparam int TO = ((p << 1) | (p >> (LOGN - 1))) & (N - 1);
        assign sh_v[TO]   = in_v[p];
        assign sh_src[TO] = in_src[p];
        assign sh_dst[TO] = in_dst[p];
        assign sh_msk[TO] = in_msk[p];
        assign sh_dat[TO] = in_dat[p];
    end

    // Column of switch elements.
    for (genvar j = 0; j < HALF; j++) begin : g_elem
        omega_switch #(.LOGN(LOGN), .DW(DW), .BIT(BIT)) i_sw (
            .up_v   (sh_v[2*j]),     .up_src (sh_src[2*j]),   .up_dst (sh_dst[2*j]),
            .up_msk (sh_msk[2*j]),   .up_dat (sh_dat[2*j]),
            .lo_v   (sh_v[2*j+1]),   .lo_src (sh_src[2*j+1]), .lo_dst (sh_dst[2*j+1]),
            .lo_msk (sh_msk[2*j+1]), .lo_dat (sh_dat[2*j+1]),
            .o0_v   (out_v[2*j]),    .o0_src (out_src[2*j]),  .o0_dst (out_dst[2*j]),
            .o0_msk (out_msk[2*j]),  .o0_dat (out_dat[2*j]),
            .o1_v   (out_v[2*j+1]),  .o1_src (out_src[2*j+1]),.o1_dst (out_dst[2*j+1]),
            .o1_msk (out_msk[2*j+1]),.o1_dat (out_dat[2*j+1]),
            .lo_lost(lost[j])
        );
    end

    // Collect the sources that lost in this column.
    always_comb begin
        blk = '0;
        for (int j = 0; j < HALF; j++)
            if (lost[j])
                blk[sh_src[2*j+1]] = 1'b1;
    end

endmodule

// File: rtl/omega_router.sv
// Omega multistage router, top level.
// Chains log2 N shuffle-and-switch columns. The inputs are routed
// combinationally and the result is registered: delivered words, their source
// index, and per-source grant and blocked flags, one clock after the request.
// Assumes N is a power of two, at least 2. Reset is synchronous and active low.
module omega_router #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N-1:0]                   in_valid,
    input  logic [N-1:0][$clog2(N)-1:0]    in_dest,
    input  logic [N-1:0][$clog2(N)-1:0]    in_mask,
    input  logic [N-1:0][DW-1:0]           in_data,
    output logic [N-1:0]                   out_valid,
    output logic [N-1:0][$clog2(N)-1:0]    out_src,
    output logic [N-1:0][DW-1:0]           out_data,
    output logic [N-1:0]                   req_grant,
    output logic [N-1:0]                   req_blocked
);

    localparam int LOGN = $clog2(N);

    logic [LOGN:0][N-1:0]           c_v;
    logic [LOGN:0][N-1:0][LOGN-1:0] c_src, c_dst, c_msk;
    logic [LOGN:0][N-1:0][DW-1:0]   c_dat;
    logic [LOGN-1:0][N-1:0]         c_blk;
    logic [N-1:0]                   blk_all;

    // Network entry lanes: each input tags itself with its own index.
    assign c_v[0]   = in_valid;
    assign c_dst[0] = in_dest;
    assign c_msk[0] = in_mask;
    assign c_dat[0] = in_data;
    for (genvar i = 0; i < N; i++) begin : g_tag
        assign c_src[0][i] = LOGN'(i);
    end

    // Columns of the network.
    for (genvar k = 0; k < LOGN; k++) begin : g_col
        omega_stage #(.N(N), .LOGN(LOGN), .DW(DW), .STAGE(k)) i_stage (
            .in_v   (c_v[k]),   .in_src (c_src[k]),   .in_dst (c_dst[k]),
            .in_msk (c_msk[k]), .in_dat (c_dat[k]),
            .out_v  (c_v[k+1]), .out_src(c_src[k+1]), .out_dst(c_dst[k+1]),
            .out_msk(c_msk[k+1]), .out_dat(c_dat[k+1]),
            .blk    (c_blk[k])
        );
    end

    // Merge per-column loss marks into one vector per source.
    always_comb begin
        blk_all = '0;
        for (int k = 0; k < LOGN; k++)
            blk_all = blk_all | c_blk[k];
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= '0;
            out_src     <= '0;
            out_data    <= '0;
            req_grant   <= '0;
            req_blocked <= '0;
        end else begin
            out_valid   <= c_v[LOGN];
            out_src     <= c_src[LOGN];
            out_data    <= c_dat[LOGN];
            req_grant   <= in_valid & ~blk_all;
            req_blocked <= in_valid & blk_all;
        end
    end

    // Shadow of the request, used only by the assertions below.
    logic [N-1:0]           vld_q;
    logic [N-1:0][LOGN-1:0] dst_q, msk_q, fdst_q, fmsk_q;

    // Capture the request so that properties can refer to its result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            dst_q  <= '0;
            msk_q  <= '0;
            fdst_q <= '0;
            fmsk_q <= '0;
        end else begin
            vld_q  <= in_valid;
            dst_q  <= in_dest;
            msk_q  <= in_mask;
            fdst_q <= c_dst[LOGN];
            fmsk_q <= c_msk[LOGN];
        end
    end

    // R2: an idle cycle leaves no delivered word on the next clock.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == '0) |=> (out_valid == '0));

    // R7: grant and blocked together cover exactly the valid requests.
    a_r7_flags_cover: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_grant | req_blocked) == vld_q) && ((req_grant & req_blocked) == '0));

    for (genvar o = 0; o < N; o++) begin : g_chk_out
        // R3 and R8: a delivered word matches its destination on the unmasked bits.
        a_r8_route_match: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (((LOGN'(o) ^ dst_q[out_src[o]]) & ~msk_q[out_src[o]]) == '0));
        // R2: a delivered word comes from an input that was valid one clock earlier.
        a_r2_src_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> vld_q[out_src[o]]);
        // R3: the lane at the network exit carries the request of its source.
        a_r3_lane_intact: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] |-> (fdst_q[o] == dst_q[out_src[o]]) && (fmsk_q[o] == msk_q[out_src[o]]));
    end

    for (genvar i = 0; i < N; i++) begin : g_chk_in
        // R3: a granted unicast shows up on its destination port.
        a_r3_unicast_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (req_grant[i] && (msk_q[i] == '0)) |->
                (out_valid[dst_q[i]] && (out_src[dst_q[i]] == LOGN'(i))));
    end

endmodule

// File: tb/test_omega_router.sv
// Directed bench for the omega router, N = 8, DW = 8.
// Every scenario task drives one request cycle at a falling edge. It checks
// the registered result at the next falling edge against paths derived by hand.
module test_omega_router;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int DW   = 8;
    localparam int LOGN = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           in_valid;
    logic [N-1:0][LOGN-1:0] in_dest, in_mask;
    logic [N-1:0][DW-1:0]   in_data;
    logic [N-1:0]           out_valid;
    logic [N-1:0][LOGN-1:0] out_src;
    logic [N-1:0][DW-1:0]   out_data;
    logic [N-1:0]           req_grant, req_blocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    omega_router #(.N(N), .DW(DW)) i_omega_router (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dest(in_dest), .in_mask(in_mask), .in_data(in_data),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
        .req_grant(req_grant), .req_blocked(req_blocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] word_of(input int src);
        return DW'(8'hA0 + src);
    endfunction

    task automatic check_val(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Clear all requests; data keeps a per-source signature.
    task automatic clear_req();
        in_valid = '0;
        in_dest  = '0;
        in_mask  = '0;
        for (int i = 0; i < N; i++) in_data[i] = word_of(i);
    endtask

    task automatic set_req(input int i, input int d, input int m);
        in_valid[i] = 1'b1;
        in_dest[i]  = LOGN'(d);
        in_mask[i]  = LOGN'(m);
    endtask

    // Wait through one rising edge and compare the registered result.
    task automatic check_net(input string req, input logic [N-1:0] ev,
                             input logic [N-1:0][LOGN-1:0] es,
                             input logic [N-1:0] eg, input logic [N-1:0] eb);
        @(negedge clk);
        check_val(req, "out_valid", int'(out_valid), int'(ev));
        check_val(req, "req_grant", int'(req_grant), int'(eg));
        check_val(req, "req_blocked", int'(req_blocked), int'(eb));
        for (int o = 0; o < N; o++) begin
            if (ev[o]) begin
                check_val(req, $sformatf("out_src[%0d]", o), int'(out_src[o]), int'(es[o]));
                check_val(req, $sformatf("out_data[%0d]", o), int'(out_data[o]), int'(word_of(int'(es[o]))));
            end
        end
        clear_req();
    endtask

    task automatic t_reset();
        logic [N-1:0][LOGN-1:0] es = '0;
        clear_req();
        for (int i = 0; i < N; i++) set_req(i, i, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_val("R1", "out_valid in reset", int'(out_valid), 0);
        check_val("R1", "req_grant in reset", int'(req_grant), 0);
        check_val("R1", "req_blocked in reset", int'(req_blocked), 0);
        check_val("R1", "out_data[0] in reset", int'(out_data[0]), 0);
        check_val("R1", "out_src[7] in reset", int'(out_src[7]), 0);
        clear_req();
        rst_n = 1'b1;
        check_net("R1", '0, es, '0, '0);
    endtask

    task automatic t_single_then_idle();
        logic [N-1:0][LOGN-1:0] es = '0;
        clear_req();
        set_req(3, 6, 0);
        es[6] = 3'd3;
        check_net("R3", 8'b0100_0000, es, 8'b0000_1000, '0);
        // R2: garbage destinations and masks with valid low deliver nothing.
        for (int i = 0; i < N; i++) begin
            in_dest[i] = 3'd5;
            in_mask[i] = 3'd7;
        end
        check_net("R2", '0, es, '0, '0);
    endtask

    task automatic t_patterns();
        logic [N-1:0][LOGN-1:0] es;
        clear_req();
        for (int i = 0; i < N; i++) begin
            set_req(i, i, 0);
            es[i] = LOGN'(i);
        end
        check_net("R4", '1, es, '1, '0);
        for (int i = 0; i < N; i++) begin
            set_req(i, (i + 3) % N, 0);
            es[(i + 3) % N] = LOGN'(i);
        end
        check_net("R4", '1, es, '1, '0);
    endtask

    task automatic t_first_column();
        logic [N-1:0][LOGN-1:0] es = '0;
        clear_req();
        set_req(0, 1, 0);
        set_req(4, 0, 0);
        es[1] = 3'd0;
        check_net("R5", 8'b0000_0010, es, 8'b0000_0001, 8'b0001_0000);
        set_req(0, 4, 0);
        set_req(4, 5, 0);
        es[4] = 3'd0;
        check_net("R5", 8'b0001_0000, es, 8'b0000_0001, 8'b0001_0000);
    endtask

    task automatic t_later_column();
        logic [N-1:0][LOGN-1:0] es = '0;
        clear_req();
        set_req(0, 0, 0);
        set_req(2, 1, 0);
        set_req(7, 7, 0);
        es[0] = 3'd0;
        es[7] = 3'd7;
        // R7: inputs left idle raise neither flag.
        check_net("R6", 8'b1000_0001, es, 8'b1000_0001, 8'b0000_0100);
    endtask

    task automatic t_broadcast();
        logic [N-1:0][LOGN-1:0] es;
        clear_req();
        set_req(5, 0, 7);
        for (int o = 0; o < N; o++) es[o] = 3'd5;
        check_net("R8", '1, es, 8'b0010_0000, '0);
        es = '0;
        set_req(2, 1, 4);
        es[1] = 3'd2;
        es[5] = 3'd2;
        check_net("R8", 8'b0010_0010, es, 8'b0000_0100, '0);
    endtask

    task automatic t_broadcast_loses();
        logic [N-1:0][LOGN-1:0] es = '0;
        clear_req();
        set_req(4, 0, 7);
        set_req(0, 0, 0);
        es[0] = 3'd0;
        check_net("R9", 8'b0000_0001, es, 8'b0000_0001, 8'b0001_0000);
        set_req(1, 0, 7);
        set_req(0, 0, 0);
        for (int o = 2; o < N; o++) es[o] = 3'd1;
        es[0] = 3'd0;
        check_net("R9", 8'b1111_1101, es, 8'b0000_0001, 8'b0000_0010);
    endtask

    task automatic t_broadcast_wins();
        logic [N-1:0][LOGN-1:0] es;
        clear_req();
        set_req(0, 0, 7);
        set_req(4, 3, 0);
        for (int o = 0; o < N; o++) es[o] = 3'd0;
        check_net("R10", '1, es, 8'b0000_0001, 8'b0001_0000);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        clear_req();
        @(negedge clk);
        t_reset();
        t_single_then_idle();
        t_patterns();
        t_first_column();
        t_later_column();
        t_broadcast();
        t_broadcast_loses();
        t_broadcast_wins();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule